// File: doc/BRIEF.md
# Multi-Mode Microcontroller Bus Slave

This block is the register-access port that lets a host microcontroller reach a small window of registers inside a larger device. A static strap selects one of four host bus styles. Two of them carry the low address byte on the shared data bus, and the device latches it while an address-latch-enable strobe is high. The other two present the address on a separate address bus. Two of the styles use an 8-bit address, and the other two use a 16-bit address.

Every access must be qualified by an active-low chip select. The block decodes a window of ten registers starting at a base address. It turns the host's read and write strobes into one-cycle internal read and write enables, together with a register index and write data for the register file, which lies outside the block. The shared data bus is modelled at the pad boundary as an input, an output and an output enable. In the two separate-bus styles the block also drives a wait line, which stretches each read by a fixed number of clock cycles.

All host inputs are taken to be synchronous to `clk`. Read data and the output enable follow the strobes through logic only, with no register on the path, so the data is on the bus in the same cycle the read strobe goes low.

Top module: `mcu_bus_slave`

## Requirements
- R1: Style 0 (bus_style = 0): the address is 8 bits wide. Its upper bits are zero, and its low byte is the value on bus_in at the last rising clock edge where ale was high.
- R2: Style 1 (bus_style = 1): the address is addr_in[7:0]. addr_in[15:8] and ale have no effect on decoding.
- R3: Style 2 (bus_style = 2): the address is {addr_in[15:8], the byte latched from bus_in while ale was high}. addr_in[7:0] has no effect.
- R4: Style 3 (bus_style = 3): the address is the full 16-bit addr_in.
- R5: An access hits only while cs_n is low and the address lies in BASE_ADDR to BASE_ADDR+9 (default 0x0040 to 0x0049). reg_rd_idx is the address minus BASE_ADDR on a hit and 0 otherwise.
- R6: bus_oe is 1 exactly while both cs_n and rd_n are low, with no clock delay.
- R7: bus_out equals reg_rdata while bus_oe is 1 and the access hits. In every other case it is 0x00, so a read outside the window returns 0x00.
- R8: reg_rd_en is high for exactly one cycle, after the first rising edge at which rd_n is sampled low following a high sample, provided the access hits at that edge.
- R9: After the first rising edge at which wr_n is sampled high following a low sample, reg_wr_en is high for one cycle. reg_wdata and reg_wr_idx then hold the bus_in value and the index sampled at the last edge where wr_n was low. There is no pulse if that last sample did not hit.
- R10: In styles 1 and 3, wait_o rises with no clock delay when cs_n and rd_n are both low. It stays high for WAIT_CYCLES rising edges (default 3), then stays low until rd_n or cs_n returns high.
- R11: In styles 0 and 2, wait_o is always 0.
- R12: During reset, bus_oe, wait_o, reg_rd_en and reg_wr_en are 0, and reg_wdata and reg_wr_idx are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_style | input | 2 | Host bus style strap, 0 to 3 |
| cs_n | input | 1 | Active-low chip select |
| ale | input | 1 | Address latch enable for the multiplexed styles |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr_in | input | 16 | Separate address bus |
| bus_in | input | 8 | Shared data bus, input side |
| bus_out | output | 8 | Shared data bus, output side |
| bus_oe | output | 1 | Shared data bus output enable |
| wait_o | output | 1 | Wait request to the host |
| reg_rd_en | output | 1 | Internal read enable pulse |
| reg_rd_idx | output | 4 | Decoded register index |
| reg_rdata | input | 8 | Read data from the register file |
| reg_wr_en | output | 1 | Internal write enable pulse |
| reg_wr_idx | output | 4 | Register index of the write |
| reg_wdata | output | 8 | Write data |

## Verification
A stale or wrong latched address byte shows up on reg_rd_idx and bus_out within the same cycle as the next read. The comparison at every clock therefore catches a bad latch at the first access after it. A wrong edge-detect register shows one clock later, either as a missing or doubled reg_rd_en or reg_wr_en pulse, or as write data taken from the wrong cycle. A wait counter that is off by one, or that fails to clear, changes the number of cycles wait_o stays high during the very read in which it goes wrong.

// File: rtl/mcu_slave_pkg.sv
package mcu_slave_pkg;

   typedef enum logic [1:0] {
      BUS_MUX8  = 2'd0,
      BUS_SEP8  = 2'd1,
      BUS_MUX16 = 2'd2,
      BUS_SEP16 = 2'd3
   } bus_style_e;

   // The low address byte travels on the data bus.
   function automatic logic style_is_mux(bus_style_e s);
      return (s == BUS_MUX8) || (s == BUS_MUX16);
   endfunction

   // Styles that stretch reads with the wait line.
   function automatic logic style_has_wait(bus_style_e s);
      return (s == BUS_SEP8) || (s == BUS_SEP16);
   endfunction

endpackage

// File: rtl/mcu_addr_path.sv
module mcu_addr_path
   import mcu_slave_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int NUM_REGS  = 10,
   parameter int BASE_ADDR = 'h40,
   parameter int IDX_W     = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_style_e        style,
   input  logic              ale,
   input  logic              cs_n,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] bus_in,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);

   localparam int HI_W = ADDR_W - DATA_W;

   logic [DATA_W-1:0] lo_q;
   logic [ADDR_W-1:0] full_addr;
   logic [ADDR_W-1:0] offset;
   logic              in_window;

   // Low byte follows the data bus while ale is high and holds once it falls.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
      end else if (ale && style_is_mux(style)) begin
         lo_q <= bus_in;
      end
   end

   always_comb begin
      unique case (style)
         BUS_MUX8:  full_addr = {{HI_W{1'b0}}, lo_q};
         BUS_SEP8:  full_addr = {{HI_W{1'b0}}, addr_in[DATA_W-1:0]};
         BUS_MUX16: full_addr = {addr_in[ADDR_W-1:DATA_W], lo_q};
         default:   full_addr = addr_in;
      endcase
   end

   assign offset    = full_addr - ADDR_W'(BASE_ADDR);
   assign in_window = (full_addr >= ADDR_W'(BASE_ADDR)) &&
                      (offset < ADDR_W'(NUM_REGS));
   assign hit       = !cs_n && in_window;
   assign idx       = hit ? offset[IDX_W-1:0] : '0;

endmodule

// File: rtl/mcu_strobe_ctl.sv
module mcu_strobe_ctl #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] bus_in,
   input  logic              hit,
   input  logic [IDX_W-1:0]  idx,
   output logic              rd_pulse,
   output logic              wr_pulse,
   output logic [DATA_W-1:0] wdata,
   output logic [IDX_W-1:0]  widx
);

   logic rd_prev;
   logic wr_prev;
   logic whit;

   // Read: one pulse on the first low sample of the strobe.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_prev  <= 1'b1;
         rd_pulse <= 1'b0;
      end else begin
         rd_prev  <= rd_n;
         rd_pulse <= !rd_n && rd_prev && hit;
      end
   end

   // Write: track bus and target while the strobe is low, commit on its rise.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_prev  <= 1'b1;
         wr_pulse <= 1'b0;
         whit     <= 1'b0;
         wdata    <= '0;
         widx     <= '0;
      end else begin
         wr_prev  <= wr_n;
         wr_pulse <= wr_n && !wr_prev && whit;
         if (!wr_n) begin
            wdata <= bus_in;
            widx  <= idx;
            whit  <= hit;
         end
      end
   end

endmodule

// File: rtl/mcu_wait_gen.sv
module mcu_wait_gen #(
   parameter int WAIT_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic cs_n,
   input  logic rd_n,
   output logic wait_o
);

   generate
      if (WAIT_CYCLES == 0) begin : g_no_wait
         assign wait_o = 1'b0;
      end else begin : g_wait
         localparam int CNT_W = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

         logic [CNT_W-1:0] cnt_q;
         logic             done_q;
         logic             active;

         assign active = enable && !cs_n && !rd_n;
         assign wait_o = active && !done_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               done_q <= 1'b0;
            end else if (cs_n || rd_n) begin
               cnt_q  <= '0;
               done_q <= 1'b0;
            end else if (wait_o) begin
               if (cnt_q == LAST) begin
                  cnt_q  <= '0;
                  done_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/mcu_bus_slave.sv
module mcu_bus_slave
   import mcu_slave_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int NUM_REGS    = 10,
   parameter int BASE_ADDR   = 'h40,
   parameter int WAIT_CYCLES = 3,
   parameter int IDX_W       = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_style,
   input  logic              cs_n,
   input  logic              ale,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   output logic              wait_o,
   output logic              reg_rd_en,
   output logic [IDX_W-1:0]  reg_rd_idx,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic              reg_wr_en,
   output logic [IDX_W-1:0]  reg_wr_idx,
   output logic [DATA_W-1:0] reg_wdata
);

   generate
      if (ADDR_W <= DATA_W) begin : g_bad_width
         $error("ADDR_W must exceed DATA_W");
      end
      if (NUM_REGS < 2) begin : g_bad_regs
         $error("NUM_REGS must be at least 2");
      end
      if (BASE_ADDR + NUM_REGS > (1 << DATA_W)) begin : g_bad_base
         $error("register window must be reachable with an 8-bit address");
      end
      if (WAIT_CYCLES < 0) begin : g_bad_wait
         $error("WAIT_CYCLES must not be negative");
      end
   endgenerate

   bus_style_e style;
   logic       hit;

   assign style = bus_style_e'(bus_style);

   mcu_addr_path #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .NUM_REGS  (NUM_REGS),
      .BASE_ADDR (BASE_ADDR),
      .IDX_W     (IDX_W)
   ) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .style   (style),
      .ale     (ale),
      .cs_n    (cs_n),
      .addr_in (addr_in),
      .bus_in  (bus_in),
      .hit     (hit),
      .idx     (reg_rd_idx)
   );

   mcu_strobe_ctl #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_n     (rd_n),
      .wr_n     (wr_n),
      .bus_in   (bus_in),
      .hit      (hit),
      .idx      (reg_rd_idx),
      .rd_pulse (reg_rd_en),
      .wr_pulse (reg_wr_en),
      .wdata    (reg_wdata),
      .widx     (reg_wr_idx)
   );

   mcu_wait_gen #(
      .WAIT_CYCLES (WAIT_CYCLES)
   ) u_wait (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (style_has_wait(style)),
      .cs_n   (cs_n),
      .rd_n   (rd_n),
      .wait_o (wait_o)
   );

   // Pad-side drive: no register between strobe and bus.
   assign bus_oe  = !cs_n && !rd_n;
   assign bus_out = (bus_oe && hit) ? reg_rdata : '0;

endmodule

// File: rtl/mcu_bus_slave_chk.sv
module mcu_bus_slave_chk #(
   parameter int DATA_W      = 8,
   parameter int WAIT_CYCLES = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        bus_style,
   input logic              cs_n,
   input logic              rd_n,
   input logic              wr_n,
   input logic              bus_oe,
   input logic [DATA_W-1:0] bus_out,
   input logic              wait_o,
   input logic              reg_rd_en,
   input logic              reg_wr_en
);

   logic [31:0] wait_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_run <= '0;
      else if (wait_o) wait_run <= wait_run + 1;
      else wait_run <= '0;
   end

   p_oe_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || rd_n) |-> (!bus_oe && bus_out == '0));

   p_rd_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_en |=> !reg_rd_en);

   p_rd_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_en |-> ($past(!rd_n) && $past(!cs_n)));

   p_wr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> !reg_wr_en);

   p_wr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> ($past(wr_n) && !$past(wr_n, 2)));

   p_wait_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wait_o |-> (wait_run < 32'(WAIT_CYCLES)));

   p_wait_stays_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(wait_o) && !rd_n && !cs_n) |=> (!wait_o || rd_n || cs_n || $past(rd_n)));

   p_no_wait_mux_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_style == 2'd0 || bus_style == 2'd2) |-> !wait_o);

endmodule

bind mcu_bus_slave mcu_bus_slave_chk #(
   .DATA_W      (DATA_W),
   .WAIT_CYCLES (WAIT_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_style (bus_style),
   .cs_n      (cs_n),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .bus_oe    (bus_oe),
   .bus_out   (bus_out),
   .wait_o    (wait_o),
   .reg_rd_en (reg_rd_en),
   .reg_wr_en (reg_wr_en)
);

// File: tb/mcu_bus_slave_test.sv
`timescale 1ns/1ps
module mcu_bus_slave_test;

   localparam int BASE  = 'h40;
   localparam int NREG  = 10;
   localparam int WAITN = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_style = 2'd0;
   logic       cs_n = 1'b1, ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
   logic [15:0] addr_in = '0;
   logic [7:0] bus_in = '0;
   logic [7:0] bus_out, reg_rdata, reg_wdata;
   logic       bus_oe, wait_o, reg_rd_en, reg_wr_en;
   logic [3:0] reg_rd_idx, reg_wr_idx;

   int n_chk = 0;
   int n_fail = 0;

   // Model state
   int m_lo = 0, m_rd_prev = 1, m_wr_prev = 1, m_cnt = 0, m_done = 0;
   int m_wdata = 0, m_widx = 0, m_whit = 0, m_rd_en = 0, m_wr_en = 0;

   always #2.5 clk = ~clk;

   function automatic int rdata_of(int i);
      return (8'h5A ^ (i * 19)) & 8'hFF;
   endfunction

   assign reg_rdata = 8'(rdata_of(int'(reg_rd_idx)));

   mcu_bus_slave uut (
      .clk(clk), .rst_n(rst_n), .bus_style(bus_style), .cs_n(cs_n), .ale(ale),
      .rd_n(rd_n), .wr_n(wr_n), .addr_in(addr_in), .bus_in(bus_in),
      .bus_out(bus_out), .bus_oe(bus_oe), .wait_o(wait_o),
      .reg_rd_en(reg_rd_en), .reg_rd_idx(reg_rd_idx), .reg_rdata(reg_rdata),
      .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wdata(reg_wdata)
   );

   function automatic int m_full();
      case (bus_style)
         2'd0: return m_lo;
         2'd1: return int'(addr_in[7:0]);
         2'd2: return (int'(addr_in[15:8]) << 8) | m_lo;
         default: return int'(addr_in);
      endcase
   endfunction

   function automatic int m_hit();
      int a = m_full();
      return (!cs_n && a >= BASE && a < BASE + NREG) ? 1 : 0;
   endfunction

   function automatic int m_idx();
      return m_hit() ? m_full() - BASE : 0;
   endfunction

   function automatic int m_wait();
      int w = (bus_style == 2'd1 || bus_style == 2'd3) ? 1 : 0;
      return (w && !cs_n && !rd_n && !m_done) ? 1 : 0;
   endfunction

   function automatic string style_tag();
      case (bus_style)
         2'd0: return "R1";
         2'd1: return "R2";
         2'd2: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      int hit, idx, oe, nrd, nwr;
      #1;
      hit = m_hit();
      idx = m_idx();
      oe  = (!cs_n && !rd_n) ? 1 : 0;
      chk("R6 bus_oe", int'(bus_oe), oe);
      chk(hit ? "R7 bus_out hit" : "R7 bus_out miss", int'(bus_out),
          (oe && hit) ? rdata_of(idx) : 0);
      if (bus_style == 2'd1 || bus_style == 2'd3) chk("R10 wait_o", int'(wait_o), m_wait());
      else chk("R11 wait_o", int'(wait_o), 0);
      if (hit) chk(style_tag(), int'(reg_rd_idx), idx);
      else chk("R5 idx on miss", int'(reg_rd_idx), 0);
      @(posedge clk);
      nrd = (!rd_n && m_rd_prev && hit) ? 1 : 0;
      nwr = (wr_n && !m_wr_prev && m_whit) ? 1 : 0;
      if (!wr_n) begin
         m_wdata = int'(bus_in);
         m_widx  = idx;
         m_whit  = hit;
      end
      if (rd_n || cs_n) begin
         m_cnt = 0; m_done = 0;
      end else if (m_wait()) begin
         if (m_cnt == WAITN - 1) begin m_done = 1; m_cnt = 0; end
         else m_cnt++;
      end
      if (ale && (bus_style == 2'd0 || bus_style == 2'd2)) m_lo = int'(bus_in);
      m_rd_prev = rd_n;
      m_wr_prev = wr_n;
      m_rd_en = nrd;
      m_wr_en = nwr;
      @(negedge clk);
      chk("R8 reg_rd_en", int'(reg_rd_en), m_rd_en);
      chk("R9 reg_wr_en", int'(reg_wr_en), m_wr_en);
      chk("R9 reg_wdata", int'(reg_wdata), m_wdata);
      chk("R9 reg_wr_idx", int'(reg_wr_idx), m_widx);
   endtask

   task automatic set_addr(int a);
      if (bus_style == 2'd0 || bus_style == 2'd2) begin
         addr_in = {8'(a >> 8), 8'hC3};
         bus_in  = 8'(a);
         ale = 1'b1;
         tick();
         ale = 1'b0;
         bus_in = 8'hE7;
         tick();
      end else begin
         addr_in = 16'(a);
         tick();
      end
   endtask

   task automatic do_read(int a, bit sel, int hold);
      set_addr(a);
      cs_n = !sel;
      rd_n = 1'b0;
      for (int i = 0; i < hold; i++) tick();
      rd_n = 1'b1;
      tick();
      cs_n = 1'b1;
      tick();
   endtask

   task automatic do_write(int a, int d, bit sel);
      set_addr(a);
      cs_n = !sel;
      bus_in = 8'(d);
      wr_n = 1'b0;
      tick();
      tick();
      wr_n = 1'b1;
      tick();
      cs_n = 1'b1;
      bus_in = 8'h00;
      tick();
      tick();
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      chk("R12 bus_oe", int'(bus_oe), 0);
      chk("R12 wait_o", int'(wait_o), 0);
      chk("R12 reg_rd_en", int'(reg_rd_en), 0);
      chk("R12 reg_wr_en", int'(reg_wr_en), 0);
      chk("R12 reg_wdata", int'(reg_wdata), 0);
      chk("R12 reg_wr_idx", int'(reg_wr_idx), 0);
      rst_n = 1'b1;
      tick();

      // Style 0: R1, window edges for R5, R7 miss data
      bus_style = 2'd0;
      do_read('h40, 1, 4);
      do_read('h49, 1, 2);
      do_read('h4A, 1, 2);
      do_read('h3F, 1, 2);
      do_write('h45, 'h3C, 1);
      do_write('h46, 'h11, 0);
      do_read('h42, 0, 2);

      // Style 1: R2, upper byte and ale ignored, wait R10
      bus_style = 2'd1;
      tick();
      ale = 1'b1; bus_in = 8'h47;
      do_read('h1242, 1, 6);
      ale = 1'b0;
      do_read('h4A, 1, 3);
      do_write('h48, 'hA7, 1);
      do_read('h44, 1, 2);
      do_read('h43, 0, 4);

      // Style 2: R3
      bus_style = 2'd2;
      tick();
      do_read('h0043, 1, 4);
      do_read('h0143, 1, 2);
      do_write('h0049, 'h5E, 1);
      do_write('h0149, 'h77, 1);

      // Style 3: R4
      bus_style = 2'd3;
      tick();
      do_read('h0041, 1, 5);
      do_read('h1241, 1, 4);
      do_write('h0040, 'hC1, 1);
      do_read('h0047, 1, 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule